// File: doc/BRIEF.md
# PLL Lock Monitor with Divided-Clock Fallback

This block runs on the PLL output clock and decides how often the memory controller may act. While the PLL reports that it has not locked, the controller's clock enable pulses once every eight cycles, which gives a divide-by-8 of the still-settling PLL output. Once lock is reported, the enable is held high every cycle and the controller runs at the full PLL rate. A change of source takes effect only where a divide-by-8 period ends, so the controller never sees a shortened period. After a wake-up, lock normally arrives within about 2 ms when the PLL reference is a low-power oscillator that is already running. Until then, the block keeps the controller on the safe divided rate.

Software sees an 8-bit read-only status byte. It holds the live level of the crystal input, the clock source currently in use, and a sticky flag that records any loss of lock. Writing a 1 to the flag clears it. The flag also drives an interrupt output. The lock input and the crystal input are both asynchronous, and each passes through a two-flop synchroniser before it is used.

Top module: `pll_lock_mon`

## Requirements
- R1: Bits 7 to 3 of `stat_o` always read as zero.
- R2: Bit 2 of `stat_o` shows the crystal input level after two synchronising flops. It follows a change on `xtal_i` two clock edges later.
- R3: Bit 1 of `stat_o` is 1 while the full-rate source is selected and 0 while the divide-by-8 source is selected. It reads 0 after reset.
- R4: Bit 0 of `stat_o` sets on the edge after the synchronised lock signal falls from 1 to 0. In terms of the ports, that is three edges after `pll_lock_i` falls.
- R5: A cycle with `stat_wr_i`=1 and `stat_wdata_i[0]`=1 clears bit 0 at the next edge.
- R6: A write with `stat_wdata_i[0]`=0 leaves bit 0 unchanged. Bits 7 to 1 of the write data have no effect.
- R7: If a lock-loss event and a clearing write fall in the same cycle, bit 0 ends up set.
- R8: `lost_irq_o` equals bit 0 of `stat_o` in every cycle.
- R9: While the divide-by-8 source is selected, `mem_clk_en_o` is high for exactly one cycle out of every eight. It is high in the last phase of a free-running 3-bit phase counter that reset sets to 0.
- R10: While the full-rate source is selected, `mem_clk_en_o` is high in every cycle.
- R11: The source select changes only at the edge that ends phase 7. At that edge it takes the synchronised lock level.
- R12: Reset is synchronous and active high. It clears the synchronisers, the phase counter, the source select and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock_i | input | 1 | Asynchronous PLL lock indication |
| xtal_i | input | 1 | Asynchronous crystal input level |
| stat_wr_i | input | 1 | Write strobe for the status byte |
| stat_wdata_i | input | 8 | Write data; bit 0 = 1 clears the lock-loss flag |
| stat_o | output | 8 | Status byte: {5'b0, crystal, full-rate, lock-lost} |
| lost_irq_o | output | 1 | Lock-loss interrupt |
| mem_clk_en_o | output | 1 | Clock enable for the memory controller |

## Verification
The hardest case to reach from the ports is a clearing write that lands in exactly the cycle in which a lock drop, delayed by three flops, sets the flag. Random traffic rarely hits that alignment. A directed sequence therefore drops `pll_lock_i`, counts two edges and then asserts the clearing write. A second hard case is a lock change that arrives partway through a divide-by-8 period. Random lock holds of varying length, from a single cycle to dozens, push the switch point across every phase. A cycle model in the bench predicts where the source select may change.

// File: rtl/pll_lock_mon_pkg.sv
package pll_lock_mon_pkg;
    localparam int DIV_LOG2    = 3;
    localparam int SYNC_STAGES = 2;
    localparam int STAT_W      = 8;
    localparam int CLR_BIT     = 0;

    typedef struct packed {
        logic [STAT_W-4:0] rsvd;
        logic              xtal;
        logic              full_rate;
        logic              lost;
    } stat_t;

    function automatic logic phase_is_last(input logic [DIV_LOG2-1:0] ph);
        return ph == {DIV_LOG2{1'b1}};
    endfunction
endpackage

// File: rtl/plm_sync.sv
module plm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= (s == 0) ? d_i : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/plm_clk_sel.sv
module plm_clk_sel
    import pll_lock_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lock_s_i,
    output logic full_o,
    output logic en_o
);
    logic [DIV_LOG2-1:0] phase;
    logic                last;
    logic                full_q;

    assign last = phase_is_last(phase);

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)       full_q <= 1'b0;
        else if (last) full_q <= lock_s_i;
    end

    assign full_o = full_q;
    assign en_o   = full_q | last;

    p_switch_boundary_r11: assert property (@(posedge clk) disable iff (rst)
        (full_q != $past(full_q)) |-> $past(last));
    p_divided_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (!full_q && en_o) |-> (phase == {DIV_LOG2{1'b1}}));
    p_full_rate_r10: assert property (@(posedge clk) disable iff (rst)
        full_q |-> en_o);
endmodule

// File: rtl/plm_status.sv
module plm_status
    import pll_lock_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lock_s_i,
    input  logic clr_i,
    output logic lost_o
);
    logic lock_q;
    logic fall;
    logic lost_q;

    always_ff @(posedge clk) begin
        if (rst) lock_q <= 1'b0;
        else     lock_q <= lock_s_i;
    end

    assign fall = lock_q & ~lock_s_i;

    always_ff @(posedge clk) begin
        if (rst)        lost_q <= 1'b0;
        else if (fall)  lost_q <= 1'b1;
        else if (clr_i) lost_q <= 1'b0;
    end

    assign lost_o = lost_q;

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        fall |=> lost_q);
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !fall) |=> !lost_q);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !fall) |=> $stable(lost_q));
endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon
    import pll_lock_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pll_lock_i,
    input  logic        xtal_i,
    input  logic        stat_wr_i,
    input  logic [7:0]  stat_wdata_i,
    output logic [7:0]  stat_o,
    output logic        lost_irq_o,
    output logic        mem_clk_en_o
);
    logic [1:0] sync_q;
    logic       lock_s;
    logic       xtal_s;
    logic       full;
    logic       lost;
    logic       clr;
    stat_t      stat;
    logic       unused_wdata;

    plm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({xtal_i, pll_lock_i}),
        .q_o (sync_q)
    );
    assign lock_s = sync_q[0];
    assign xtal_s = sync_q[1];

    plm_clk_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .lock_s_i (lock_s),
        .full_o   (full),
        .en_o     (mem_clk_en_o)
    );

    assign clr = stat_wr_i & stat_wdata_i[CLR_BIT];
    assign unused_wdata = ^stat_wdata_i[7:1];

    plm_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .lock_s_i (lock_s),
        .clr_i    (clr),
        .lost_o   (lost)
    );

    always_comb begin
        stat           = '0;
        stat.xtal      = xtal_s;
        stat.full_rate = full;
        stat.lost      = lost;
    end

    assign stat_o     = stat;
    assign lost_irq_o = lost;

    p_irq_match_r8: assert property (@(posedge clk) disable iff (rst)
        lost_irq_o == stat_o[0]);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        stat_o[7:3] == 5'b0);
endmodule

// File: tb/sim_pll_lock_mon.sv
`timescale 1ns/1ps
module sim_pll_lock_mon;
    logic       clk = 0;
    logic       rst = 1;
    logic       lock_in = 0, xtal_in = 0, wr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] stat;
    logic       irq, en;

    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    pll_lock_mon u0 (
        .clk(clk), .rst(rst), .pll_lock_i(lock_in), .xtal_i(xtal_in),
        .stat_wr_i(wr), .stat_wdata_i(wdata), .stat_o(stat),
        .lost_irq_o(irq), .mem_clk_en_o(en)
    );

    // bench model built from the requirements
    logic       m_l1, m_l2, m_l3, m_x1, m_x2, m_full, m_lost;
    logic [2:0] m_ph;
    always @(posedge clk) begin
        if (rst) begin
            m_l1 <= 0; m_l2 <= 0; m_l3 <= 0; m_x1 <= 0; m_x2 <= 0;
            m_ph <= 0; m_full <= 0; m_lost <= 0;
        end else begin
            m_l1 <= lock_in; m_l2 <= m_l1; m_l3 <= m_l2;
            m_x1 <= xtal_in; m_x2 <= m_x1;
            m_ph <= m_ph + 3'd1;
            if (m_ph == 3'd7) m_full <= m_l2;
            if (m_l3 && !m_l2)           m_lost <= 1;
            else if (wr && wdata[0])     m_lost <= 0;
        end
    end

    function automatic logic exp_en(input logic full, input logic [2:0] ph);
        return full || (ph == 3'd7);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R1 reserved bits", {3'b0, stat[7:3]}, 8'h00);
        chk("R2/R12 crystal bit", {7'b0, stat[2]}, {7'b0, m_x2});
        chk("R3/R11 source bit", {7'b0, stat[1]}, {7'b0, m_full});
        chk("R4/R5/R6 lost flag", {7'b0, stat[0]}, {7'b0, m_lost});
        chk("R8 irq", {7'b0, irq}, {7'b0, stat[0]});
        chk("R9/R10 enable", {7'b0, en}, {7'b0, exp_en(m_full, m_ph)});
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int seed;
        int hold;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        chk("R12 reset status", stat, 8'h00);
        chk("R12 reset irq", {7'b0, irq}, 8'h00);
        // R9 divided mode for a while
        for (int i = 0; i < 20; i++) step();
        // R10 lock, run at full rate
        lock_in = 1;
        for (int i = 0; i < 20; i++) step();
        chk("R10 full rate selected", {7'b0, stat[1]}, 8'h01);
        // R4 drop lock
        lock_in = 0;
        for (int i = 0; i < 4; i++) step();
        chk("R4 flag set after loss", {7'b0, stat[0]}, 8'h01);
        // R6 write zero and upper bits do nothing
        wr = 1; wdata = 8'hFE; step(); wr = 0; wdata = 0; step();
        chk("R6 write 0 ignored", {7'b0, stat[0]}, 8'h01);
        // R5 clear
        wr = 1; wdata = 8'h01; step(); wr = 0; wdata = 0; step();
        chk("R5 cleared by W1C", {7'b0, stat[0]}, 8'h00);
        // R7 collision: relock, then drop and clear in the cycle the set lands
        lock_in = 1;
        for (int i = 0; i < 12; i++) step();
        lock_in = 0; step(); step();
        wr = 1; wdata = 8'h01; step(); wr = 0; wdata = 0;
        chk("R7 set wins over clear", {7'b0, stat[0]}, 8'h01);
        step();
        // R2 crystal following
        xtal_in = 1; step(); chk("R2 xtal one edge", {7'b0, stat[2]}, 8'h00);
        step(); chk("R2 xtal two edges", {7'b0, stat[2]}, 8'h01);
        xtal_in = 0;
        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) lock_in = ~lock_in;
            xtal_in = $urandom_range(0, 1);
            wr      = ($urandom_range(0, 7) == 0);
            wdata   = 8'($urandom);
            hold    = $urandom_range(1, 3);
            for (int k = 0; k < hold; k++) step();
        end
        wr = 0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule